// File: doc/BRIEF.md
# Interpolator Pool Dispatcher and Rundown Timestamper

This block is the digital back end of a time-to-digital converter made of a pool of identical, slow analog interpolators. Each interpolator charges a capacitor from an input event to the next reference clock edge. It then discharges at a far smaller current, so the short interval is stretched by the ratio of the two currents (nominally 10000). At a 10 ns reference period, one counted rundown cycle is therefore worth about 1 ps.

When an event arrives, the block hands it to a free interpolator. The unit to use is already chosen one clock earlier, so no decision is made on the event path. The block latches a free-running coarse cycle count into the chosen unit's slot. It then counts that unit's rundown in reference cycles until the comparator reports completion. Finished results leave on a valid/ready stream, in the order the units finished. Each result carries the unit index, the coarse count, the fine count, a good/timed-out flag and a combined timestamp in picoseconds.

A unit is released only when its result has been taken from the stream. If an event finds every unit busy, it is dropped, a sticky flag is raised and a saturating drop counter advances. A rundown that never ends is cut off at a programmable limit, and its result is flagged as not good.

Top module: `tdc_pool_dispatch`

## Requirements
- R1: After reset, unit_start is all zero, res_valid, overflow and drop_count are zero, the coarse counter is zero and the first assigned event goes to unit 0.
- R2: An event sampled high at a rising edge while a unit is free raises exactly that unit's bit of unit_start for the one cycle after that edge. unit_start never has more than one bit set.
- R3: The unit chosen is the first free one found by scanning upward from the unit after the last assigned unit, wrapping from the highest index to 0.
- R4: An event that finds no free unit issues no start. It sets overflow, which stays set until reset, and increments drop_count, which saturates at all ones.
- R5: res_coarse equals the free-running cycle counter at the assigning edge. That counter reads 0 at the first edge after reset, advances by one per edge and wraps.
- R6: res_fine counts the rising edges after the assigning edge at which the unit's done input was low, up to the edge that samples it high. Such a result has res_ok = 1.
- R7: If the count equals rundown_limit at an edge where done is low, the unit finishes with res_ok = 0 and res_fine = rundown_limit. A done seen at that same edge still gives res_ok = 1.
- R8: res_stamp equals res_coarse × STRETCH − res_fine, modulo 2^STAMP_W.
- R9: Results leave in the order of their finishing edges, with finishes at the same edge ordered lowest unit index first. One result is removed per clock, at an edge where res_valid and res_ready are both high. While res_ready is low, the presented result holds steady.
- R10: A unit stays busy from assignment until its result is removed. A done pulse on a unit that is not running is ignored. A unit removed at one edge can take an event at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| event_in | input | 1 | Event strobe, one per sampled edge |
| rundown_limit | input | FINE_W | Maximum rundown count before a unit is forced free |
| unit_done | input | N_UNITS | Per-unit comparator trip (rundown finished) |
| unit_start | output | N_UNITS | One-cycle start pulse to the chosen interpolator |
| res_valid | output | 1 | A result is presented |
| res_ready | input | 1 | Consumer accepts the presented result |
| res_unit | output | IDX_W | Interpolator index of the result |
| res_coarse | output | COARSE_W | Coarse cycle count latched at assignment |
| res_fine | output | FINE_W | Rundown cycle count |
| res_ok | output | 1 | 1 = rundown ended normally, 0 = cut off at the limit |
| res_stamp | output | STAMP_W | Coarse × STRETCH − fine, in fine units |
| overflow | output | 1 | Sticky: an event was dropped |
| drop_count | output | DROP_W | Saturating count of dropped events |

## Verification
A start pulse is due in the cycle after the edge that samples the event. A result becomes valid in the cycle after the edge that sees done or reaches the limit. The overflow flag and the drop count move in the cycle after the edge of the dropped event. A removed unit can take an event at the very next edge. The bench reference model advances at each rising edge from the inputs held steady across it, and all outputs are compared with the model at the following falling edge. Each check therefore lands exactly one register stage after its cause. Scenarios cover a lone event, a saturating burst, timeouts, same-edge finishes under backpressure, and random traffic with stray done pulses.

// File: rtl/tdc_pool_pkg.sv
`timescale 1ns/1ps
// Shared types for the interpolator pool dispatcher.
// Assumes: nothing beyond standard SystemVerilog.
package tdc_pool_pkg;

    // Life cycle of one interpolator slot
    typedef enum logic [1:0] {
        SLOT_FREE = 2'd0,   // idle, may be assigned
        SLOT_RUN  = 2'd1,   // charging / running down, counting
        SLOT_HELD = 2'd2    // result captured, waiting to leave the stream
    } slot_state_e;

endpackage

// File: rtl/tdc_rr_picker.sv
`timescale 1ns/1ps
// Round-robin free-unit picker.
// Finds the first set bit of free_mask scanning upward from last_idx+1,
// wrapping at N_UNITS. Purely combinational; the top registers its result
// one cycle ahead so the event path only sees a flop (R3).
// Assumes: last_idx < N_UNITS.
module tdc_rr_picker #(
    parameter int N_UNITS = 16,
    parameter int IDX_W   = 4
) (
    input  logic [N_UNITS-1:0] free_mask,
    input  logic [IDX_W-1:0]   last_idx,
    output logic [IDX_W-1:0]   pick_idx,
    output logic               pick_ok
);

    // Scan far-to-near so the nearest candidate is written last
    always_comb begin
        int cand;
        pick_idx = '0;
        pick_ok  = 1'b0;
        cand     = 0;
        for (int k = N_UNITS; k >= 1; k--) begin
            cand = (int'(last_idx) + k) % N_UNITS;
            if (free_mask[cand]) begin
                pick_idx = IDX_W'(cand);
                pick_ok  = 1'b1;
            end
        end
    end

endmodule

// File: rtl/tdc_slot.sv
`timescale 1ns/1ps
// One interpolator slot: start pulse, rundown counter, result hold.
// Assumes: assign_i only rises while the slot is free and pop_i only while
// the slot holds a result (both guaranteed by the top).
module tdc_slot
    import tdc_pool_pkg::*;
#(
    parameter int COARSE_W = 24,
    parameter int FINE_W   = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                assign_i,
    input  logic [COARSE_W-1:0] coarse_i,
    input  logic                done_i,
    input  logic [FINE_W-1:0]   limit_i,
    input  logic                pop_i,
    output logic                start_o,
    output logic                finish_o,
    output logic                free_next_o,
    output logic [COARSE_W-1:0] coarse_o,
    output logic [FINE_W-1:0]   fine_o,
    output logic                ok_o
);

    slot_state_e         state_q;
    logic [FINE_W-1:0]   cnt_q;
    logic [COARSE_W-1:0] coarse_q;
    logic [FINE_W-1:0]   fine_q;
    logic                ok_q;
    logic                start_q;

    // Rundown ends on comparator trip or on reaching the limit (R6, R7)
    assign finish_o = (state_q == SLOT_RUN) && (done_i || (cnt_q == limit_i));

    // Slot will be free after this edge (feeds the one-ahead picker, R10)
    assign free_next_o = ((state_q == SLOT_FREE) && !assign_i) ||
                         ((state_q == SLOT_HELD) && pop_i);

    // State, counter and result capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= SLOT_FREE;
            cnt_q    <= '0;
            coarse_q <= '0;
            fine_q   <= '0;
            ok_q     <= 1'b0;
            start_q  <= 1'b0;
        end else begin
            start_q <= assign_i;
            case (state_q)
                SLOT_FREE: begin
                    if (assign_i) begin
                        state_q  <= SLOT_RUN;
                        cnt_q    <= '0;
                        coarse_q <= coarse_i;
                    end
                end
                SLOT_RUN: begin
                    if (finish_o) begin
                        state_q <= SLOT_HELD;
                        fine_q  <= cnt_q;
                        ok_q    <= done_i;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                SLOT_HELD: begin
                    if (pop_i) state_q <= SLOT_FREE;
                end
                default: state_q <= SLOT_FREE;
            endcase
        end
    end

    assign start_o  = start_q;
    assign coarse_o = coarse_q;
    assign fine_o   = fine_q;
    assign ok_o     = ok_q;

endmodule

// File: rtl/tdc_done_queue.sv
`timescale 1ns/1ps
// Completion-order queue of unit indices.
// Accepts any number of finishing units per edge, written lowest index
// first, and releases one index per pop (R9).
// Assumes: a unit is pushed at most once until popped, so depth N_UNITS
// can never overflow.
module tdc_done_queue #(
    parameter int N_UNITS = 16,
    parameter int IDX_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_UNITS-1:0] push_mask,
    input  logic               pop_i,
    output logic               valid_o,
    output logic [IDX_W-1:0]   head_o
);

    localparam int QW    = (N_UNITS > 1) ? $clog2(N_UNITS) : 1;
    localparam int DEPTH = 1 << QW;

    logic [IDX_W-1:0] mem_q [DEPTH];
    logic [QW:0]      wr_q, rd_q;
    logic [QW:0]      pos [N_UNITS];
    logic [QW:0]      push_cnt;

    // Write position of each pushed index: prefix count of lower pushes
    always_comb begin
        push_cnt = '0;
        for (int i = 0; i < N_UNITS; i++) begin
            pos[i] = wr_q + push_cnt;
            if (push_mask[i]) push_cnt = push_cnt + (QW+1)'(1);
        end
    end

    // Storage and pointers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q <= '0;
            rd_q <= '0;
            for (int d = 0; d < DEPTH; d++) mem_q[d] <= '0;
        end else begin
            for (int i = 0; i < N_UNITS; i++) begin
                if (push_mask[i]) mem_q[pos[i][QW-1:0]] <= IDX_W'(i);
            end
            wr_q <= wr_q + push_cnt;
            if (pop_i) rd_q <= rd_q + (QW+1)'(1);
        end
    end

    assign valid_o = (wr_q != rd_q);
    assign head_o  = mem_q[rd_q[QW-1:0]];

endmodule

// File: rtl/tdc_pool_dispatch.sv
`timescale 1ns/1ps
// Interpolator pool dispatcher with rundown counting (top).
// Hands each event to a precomputed next-free interpolator, latches the
// coarse cycle count, counts the stretched rundown and streams results in
// completion order. Drops events when the pool is full.
// Assumes: event_in and unit_done are synchronous to clk; the analog units
// start on unit_start and pulse unit_done when their rundown ends.
module tdc_pool_dispatch #(
    parameter int N_UNITS  = 16,
    parameter int COARSE_W = 24,
    parameter int FINE_W   = 16,
    parameter int DROP_W   = 16,
    parameter int STRETCH  = 10000,
    localparam int IDX_W   = (N_UNITS > 1) ? $clog2(N_UNITS) : 1,
    localparam int STAMP_W = COARSE_W + $clog2(STRETCH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                event_in,
    input  logic [FINE_W-1:0]   rundown_limit,
    input  logic [N_UNITS-1:0]  unit_done,
    output logic [N_UNITS-1:0]  unit_start,
    output logic                res_valid,
    input  logic                res_ready,
    output logic [IDX_W-1:0]    res_unit,
    output logic [COARSE_W-1:0] res_coarse,
    output logic [FINE_W-1:0]   res_fine,
    output logic                res_ok,
    output logic [STAMP_W-1:0]  res_stamp,
    output logic                overflow,
    output logic [DROP_W-1:0]   drop_count
);

    logic [COARSE_W-1:0] coarse_ctr_q;
    logic [IDX_W-1:0]    sel_idx_q, last_q, last_next, pick_idx;
    logic                sel_ok_q, pick_ok, take;
    logic                ovf_q;
    logic [DROP_W-1:0]   drop_q;

    logic [N_UNITS-1:0]  assign_vec, pop_vec, finish_vec, free_next_vec;
    logic [COARSE_W-1:0] slot_coarse [N_UNITS];
    logic [FINE_W-1:0]   slot_fine   [N_UNITS];
    logic                slot_ok     [N_UNITS];
    logic                pop;

    // An event is taken only if the precomputed choice is valid (R2, R4)
    assign take      = event_in && sel_ok_q;
    assign last_next = take ? sel_idx_q : last_q;
    assign pop       = res_valid && res_ready;

    // Free-running coarse cycle counter (R5)
    always_ff @(posedge clk) begin
        if (!rst_n) coarse_ctr_q <= '0;
        else        coarse_ctr_q <= coarse_ctr_q + 1'b1;
    end

    // Picker on next-cycle free set, so the choice is ready before the event (R3)
    tdc_rr_picker #(
        .N_UNITS (N_UNITS),
        .IDX_W   (IDX_W)
    ) u_picker (
        .free_mask (free_next_vec),
        .last_idx  (last_next),
        .pick_idx  (pick_idx),
        .pick_ok   (pick_ok)
    );

    // Registered selection and last-assigned pointer (R1, R3)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_idx_q <= '0;
            sel_ok_q  <= 1'b1;
            last_q    <= IDX_W'(N_UNITS - 1);
        end else begin
            sel_idx_q <= pick_idx;
            sel_ok_q  <= pick_ok;
            last_q    <= last_next;
        end
    end

    // Drop accounting: sticky flag and saturating counter (R4)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q  <= 1'b0;
            drop_q <= '0;
        end else if (event_in && !sel_ok_q) begin
            ovf_q <= 1'b1;
            if (drop_q != {DROP_W{1'b1}}) drop_q <= drop_q + 1'b1;
        end
    end

    // One slot per interpolator
    for (genvar g = 0; g < N_UNITS; g++) begin : g_slot
        assign assign_vec[g] = take && (sel_idx_q == IDX_W'(g));
        assign pop_vec[g]    = pop && (res_unit == IDX_W'(g));

        tdc_slot #(
            .COARSE_W (COARSE_W),
            .FINE_W   (FINE_W)
        ) u_slot (
            .clk         (clk),
            .rst_n       (rst_n),
            .assign_i    (assign_vec[g]),
            .coarse_i    (coarse_ctr_q),
            .done_i      (unit_done[g]),
            .limit_i     (rundown_limit),
            .pop_i       (pop_vec[g]),
            .start_o     (unit_start[g]),
            .finish_o    (finish_vec[g]),
            .free_next_o (free_next_vec[g]),
            .coarse_o    (slot_coarse[g]),
            .fine_o      (slot_fine[g]),
            .ok_o        (slot_ok[g])
        );
    end

    // Completion-order output queue (R9)
    tdc_done_queue #(
        .N_UNITS (N_UNITS),
        .IDX_W   (IDX_W)
    ) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_mask (finish_vec),
        .pop_i     (pop),
        .valid_o   (res_valid),
        .head_o    (res_unit)
    );

    // Result fields from the head slot and the combined timestamp (R8)
    assign res_coarse = slot_coarse[res_unit];
    assign res_fine   = slot_fine[res_unit];
    assign res_ok     = slot_ok[res_unit];
    assign res_stamp  = STAMP_W'(res_coarse) * STAMP_W'(STRETCH) - STAMP_W'(res_fine);

    assign overflow   = ovf_q;
    assign drop_count = drop_q;

endmodule

// File: rtl/tdc_pool_checker.sv
`timescale 1ns/1ps
// Protocol checker for tdc_pool_dispatch, attached by bind.
// Assumes: observes the top-level ports only.
module tdc_pool_checker #(
    parameter int N_UNITS  = 16,
    parameter int COARSE_W = 24,
    parameter int FINE_W   = 16,
    parameter int DROP_W   = 16,
    parameter int IDX_W    = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                event_in,
    input logic [N_UNITS-1:0]  unit_start,
    input logic                res_valid,
    input logic                res_ready,
    input logic [IDX_W-1:0]    res_unit,
    input logic [COARSE_W-1:0] res_coarse,
    input logic [FINE_W-1:0]   res_fine,
    input logic                res_ok,
    input logic                overflow,
    input logic [DROP_W-1:0]   drop_count
);

    // R1: first cycle out of reset is quiet
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (unit_start == '0 && !res_valid && !overflow && drop_count == '0));

    // R2: at most one start at a time
    p_start_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(unit_start));

    // R2: a start always follows a sampled event
    p_start_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_start != '0) |-> $past(event_in));

    // R4: overflow is sticky
    p_overflow_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    // R4: the drop counter only moves with overflow raised
    p_drop_flagged_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_count != $past(drop_count)) |-> overflow);

    // R9: presented result holds under backpressure
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ready) |=> (res_valid && $stable(res_unit) &&
            $stable(res_coarse) && $stable(res_fine) && $stable(res_ok)));

    // R10: a unit whose result is still presented is never restarted
    p_held_not_started_r10: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !unit_start[res_unit]);

endmodule

bind tdc_pool_dispatch tdc_pool_checker #(
    .N_UNITS  (N_UNITS),
    .COARSE_W (COARSE_W),
    .FINE_W   (FINE_W),
    .DROP_W   (DROP_W),
    .IDX_W    (IDX_W)
) u_tdc_pool_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .event_in   (event_in),
    .unit_start (unit_start),
    .res_valid  (res_valid),
    .res_ready  (res_ready),
    .res_unit   (res_unit),
    .res_coarse (res_coarse),
    .res_fine   (res_fine),
    .res_ok     (res_ok),
    .overflow   (overflow),
    .drop_count (drop_count)
);

// File: tb/test_tdc_pool_dispatch.sv
`timescale 1ns/1ps
// Bench: behavioural reference model advanced at each rising edge,
// compared with every output at each falling edge.
module test_tdc_pool_dispatch;

    localparam int N  = 16;
    localparam int CW = 24;
    localparam int FW = 16;
    localparam int DW = 6;
    localparam int ST = 10000;
    localparam int IW = 4;
    localparam int SW = CW + 14;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          event_in;
    logic [FW-1:0] rundown_limit;
    logic [N-1:0]  unit_done;
    logic [N-1:0]  unit_start;
    logic          res_valid, res_ready, res_ok, overflow;
    logic [IW-1:0] res_unit;
    logic [CW-1:0] res_coarse;
    logic [FW-1:0] res_fine;
    logic [SW-1:0] res_stamp;
    logic [DW-1:0] drop_count;

    always #5 clk = ~clk;

    tdc_pool_dispatch #(
        .N_UNITS (N), .COARSE_W (CW), .FINE_W (FW), .DROP_W (DW), .STRETCH (ST)
    ) i_tdc_pool_dispatch (
        .clk (clk), .rst_n (rst_n), .event_in (event_in),
        .rundown_limit (rundown_limit), .unit_done (unit_done),
        .unit_start (unit_start), .res_valid (res_valid), .res_ready (res_ready),
        .res_unit (res_unit), .res_coarse (res_coarse), .res_fine (res_fine),
        .res_ok (res_ok), .res_stamp (res_stamp), .overflow (overflow),
        .drop_count (drop_count)
    );

    int    n_checks = 0;
    int    n_fail   = 0;
    string phase    = "reset";
    bit    finished = 1'b0;

    task automatic chk(string tag, longint act, longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL [%s] %s actual=%0d expected=%0d", phase, tag, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    int       m_state  [N];   // 0 free, 1 running, 2 holding result
    int       m_cnt    [N];
    longint   m_coarse [N];
    int       m_fine   [N];
    bit       m_ok     [N];
    int       m_q[$];
    int       m_last;
    longint   m_cc;
    bit       m_ovf;
    int       m_drop;
    bit [N-1:0] m_start;

    always @(posedge clk) begin : model
        int os [N];
        bit nd [N];
        int found;
        int c;
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                m_state[i] = 0; m_cnt[i] = 0; m_coarse[i] = 0; m_fine[i] = 0; m_ok[i] = 0;
            end
            m_q.delete();
            m_last = N - 1; m_cc = 0; m_ovf = 0; m_drop = 0; m_start = '0;
        end else begin
            m_start = '0;
            for (int i = 0; i < N; i++) os[i] = m_state[i];
            for (int i = 0; i < N; i++) begin
                nd[i] = 1'b0;
                if (os[i] == 1) begin
                    if (unit_done[i]) begin
                        m_fine[i] = m_cnt[i]; m_ok[i] = 1'b1; nd[i] = 1'b1; m_state[i] = 2;
                    end else if (m_cnt[i] == int'(rundown_limit)) begin
                        m_fine[i] = m_cnt[i]; m_ok[i] = 1'b0; nd[i] = 1'b1; m_state[i] = 2;
                    end else begin
                        m_cnt[i]++;
                    end
                end
            end
            if (m_q.size() > 0 && res_ready) begin
                m_state[m_q[0]] = 0;
                void'(m_q.pop_front());
            end
            if (event_in) begin
                found = -1;
                for (int k = 1; k <= N; k++) begin
                    c = (m_last + k) % N;
                    if (found < 0 && os[c] == 0) found = c;
                end
                if (found >= 0) begin
                    m_state[found] = 1; m_cnt[found] = 0; m_coarse[found] = m_cc;
                    m_last = found; m_start[found] = 1'b1;
                end else begin
                    m_ovf = 1'b1;
                    if (m_drop < (1 << DW) - 1) m_drop++;
                end
            end
            for (int i = 0; i < N; i++) if (nd[i]) m_q.push_back(i);
            m_cc = (m_cc + 1) % (64'd1 << CW);
        end
    end

    // ---------------- comparison at the falling edge ----------------
    always @(negedge clk) begin
        longint exp_stamp;
        if (rst_n === 1'b1 && !finished) begin
            chk("R2 R3 unit_start", unit_start, m_start);
            chk("R9 R10 res_valid", res_valid, m_q.size() > 0);
            chk("R4 overflow", overflow, m_ovf);
            chk("R4 drop_count", drop_count, m_drop);
            if (res_valid && m_q.size() > 0) begin
                exp_stamp = (m_coarse[m_q[0]] * ST - m_fine[m_q[0]]) & ((64'sd1 << SW) - 1);
                chk("R9 res_unit", res_unit, m_q[0]);
                chk("R5 res_coarse", res_coarse, m_coarse[m_q[0]]);
                chk("R6 R7 res_fine", res_fine, m_fine[m_q[0]]);
                chk("R7 res_ok", res_ok, m_ok[m_q[0]]);
                chk("R8 res_stamp", res_stamp, exp_stamp);
            end
        end
    end

    // ---------------- analog unit stand-ins ----------------
    int dly [N];      // rundown length in cycles, -1 = never ends
    int cd  [N];
    bit armed [N];
    bit rand_dly = 1'b0;
    bit spur_en  = 1'b0;

    always @(negedge clk) begin
        logic [N-1:0] dv;
        dv = '0;
        for (int i = 0; i < N; i++) begin
            if (armed[i]) begin
                if (cd[i] == 0) begin dv[i] = 1'b1; armed[i] = 1'b0; end
                else cd[i]--;
            end
            if (rst_n === 1'b1 && unit_start[i] === 1'b1) begin
                if (rand_dly) begin armed[i] = 1'b1; cd[i] = $urandom_range(0, 30); end
                else if (dly[i] >= 0) begin armed[i] = 1'b1; cd[i] = dly[i]; end
            end
            if (spur_en && ($urandom_range(0, 15) == 0)) dv[i] = 1'b1;
        end
        unit_done = dv;
    end

    task automatic fire(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) event_in = 1'b1;
        end
        @(negedge clk) event_in = 1'b0;
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL [%s] watchdog expired actual=%0d expected=%0d", phase, 1, 0);
        finish_run();
    end

    // ---------------- stimulus ----------------
    initial begin
        rst_n = 1'b0; event_in = 1'b0; res_ready = 1'b1;
        rundown_limit = FW'(200); unit_done = '0;
        for (int i = 0; i < N; i++) begin dly[i] = 5; cd[i] = 0; armed[i] = 1'b0; end

        repeat (3) @(negedge clk);
        // R1: outputs quiet while in reset
        chk("R1 unit_start in reset", unit_start, 0);
        chk("R1 res_valid in reset", res_valid, 0);
        chk("R1 overflow in reset", overflow, 0);
        chk("R1 drop_count in reset", drop_count, 0);
        rst_n = 1'b1;

        // R1 R2 R5 R6 R8: single event goes to unit 0
        phase = "R1 R2 single";
        repeat (2) @(negedge clk);
        event_in = 1'b1;
        @(negedge clk) event_in = 1'b0;
        chk("R1 first start on unit 0", unit_start, 1);
        repeat (15) @(negedge clk);

        // R3 R4: burst beyond pool size, long rundowns
        phase = "R3 R4 burst";
        for (int i = 0; i < N; i++) dly[i] = 40;
        fire(24);
        repeat (70) @(negedge clk);

        // R4 R7: rundowns never end, drops saturate, limit cuts off
        phase = "R4 R7 timeout";
        for (int i = 0; i < N; i++) dly[i] = -1;
        fire(90);
        chk("R4 drop_count saturated", drop_count, (1 << DW) - 1);
        repeat (250) @(negedge clk);

        // R9: same-edge finishes under backpressure
        phase = "R9 ordering";
        rundown_limit = FW'(200);
        for (int i = 0; i < N; i++) dly[i] = 24 - ((i + N - 3) % N);
        fire(6);
        res_ready = 1'b0;
        repeat (40) @(negedge clk);
        res_ready = 1'b1;
        repeat (4) @(negedge clk);
        res_ready = 1'b0;
        repeat (3) @(negedge clk);
        res_ready = 1'b1;
        repeat (20) @(negedge clk);

        // R6 R7 R10: random traffic, random readiness, stray done pulses
        phase = "R10 random";
        rundown_limit = FW'(25);
        rand_dly = 1'b1;
        spur_en  = 1'b1;
        for (int t = 0; t < 3000; t++) begin
            @(negedge clk);
            event_in  = ($urandom_range(0, 9) < 3);
            res_ready = ($urandom_range(0, 9) < 7);
        end
        @(negedge clk) event_in = 1'b0;
        res_ready = 1'b1;
        spur_en   = 1'b0;
        repeat (60) @(negedge clk);

        finish_run();
    end

endmodule